// File: doc/BRIEF.md
# Dual-Row Flip-Order Difference Encoder

This block is the digital back end for a pair of adjacent pixel rows, one odd and one even. The two rows are read during the same row time on two separate column buses, and both are compared against one shared ramp. Each row's comparator flip reaches the block as a one-cycle event pulse. The pulse carries a fine tap position that gives the time from the start of that clock cycle to the flip. A coarse counter runs from the start of the conversion, so a flip's timestamp is the coarse count concatenated with the tap, in tap units.

The block latches which row flipped first. That row is the leader, and its code is the full measurement from its flip to the next rising clock edge. The block does not quantise the other row in full. It encodes only the time from the leader's flip to its own flip, as a difference code. Neighbouring rows are usually close, so the difference is small. A latched order bit routes the start and stop: the leader's flip starts both paths, the next clock edge ends the leader's path, and the follower's own flip ends the follower's path. No separate stop generator is needed.

The block also rebuilds both row values from the leader code, the difference and the order bit. The difference saturates at its field width and raises an overflow flag. Results are presented once both flips are resolved or the ramp ends.

Top module: `flip_diff_enc`

## Requirements
- R1: After reset, `valid` is 0, `orderFlag` is 0, `leadRow1` is 1, and every code output and `diffOvf` is 0.
- R2: A `convStart` pulse clears any earlier result and restarts the coarse count at 0. A flip in the k-th cycle after the start edge (k = 0 first) gets timestamp k*TAPS + tap. `TAPS` is a power of two and tap < TAPS.
- R3: If row 1 flips first, `orderFlag` stays 0, `leadRow1` stays 1 and `earlyCode` is the row-1 timestamp.
- R4: If row 2 flips first, `orderFlag` becomes 1, `leadRow1` becomes 0 and `earlyCode` is the row-2 timestamp. The flag changes in the cycle after the flip.
- R5: Once a leader is latched, later flips do not change `orderFlag` or `leadRow1`. A repeat flip from the leading row is ignored.
- R6: If both rows flip in the same cycle, the lower tap leads. Equal taps count as row 1 first, with a difference of 0.
- R7: `diffCode` equals the follower's timestamp minus the leader's timestamp.
- R8: If the difference exceeds 2^DIFF_W-1, `diffCode` is all ones and `diffOvf` is 1. Otherwise `diffOvf` is 0.
- R9: The leader's row code equals `earlyCode`. The other row's code is `earlyCode + diffCode`, clamped at the all-ones timestamp. `row1Code` and `row2Code` are chosen by `orderFlag`.
- R10: `valid` rises in the cycle after the edge that resolves the second flip or samples `rampEnd`, and it holds until the next `convStart`. Flips and `rampEnd` are ignored while idle or done. While `valid` is 0, the code outputs and `diffOvf` are 0.
- R11: If the ramp ends with only the leader resolved, `diffCode` is all ones and `diffOvf` is 1. If the ramp ends with no flip at all, `earlyCode` is all ones, `diffCode` is 0, `diffOvf` is 0 and `orderFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convStart | input | 1 | Pulse that starts a conversion and clears any earlier result |
| rampEnd | input | 1 | Pulse marking the end of the ramp |
| row1Flip | input | 1 | Row-1 (odd row) comparator flip event |
| row1Tap | input | TAP_W | Fine tap of the row-1 flip within its cycle |
| row2Flip | input | 1 | Row-2 (even row) comparator flip event |
| row2Tap | input | TAP_W | Fine tap of the row-2 flip within its cycle |
| valid | output | 1 | Results are resolved |
| orderFlag | output | 1 | 1 when row 2 led; also the sign of the difference |
| leadRow1 | output | 1 | First-arrival indicator, high while row 1 leads or no flip has arrived yet |
| earlyCode | output | CNT_W+TAP_W | Full code of the leading row |
| diffCode | output | DIFF_W | Follower minus leader, saturated |
| diffOvf | output | 1 | Difference saturated |
| row1Code | output | CNT_W+TAP_W | Rebuilt row-1 value |
| row2Code | output | CNT_W+TAP_W | Rebuilt row-2 value |

## Verification
The bench builds the block with CNT_W=5, TAPS=8 and DIFF_W=5. With these values the whole timestamp range is 0 to 255, and the difference saturates above 31 taps, about four clock cycles. That makes both overflow and ramp-end exhaustion reachable in a few dozen cycles. The small counter also lets a flip placed late in the ramp push the rebuilt follower value into its clamp at 255.

// File: rtl/flip_diff_pkg.sv
package flip_diff_pkg;

  // Strobes sent from the control FSM to the datapath each cycle
  typedef struct packed {
    logic clear;      // restart conversion
    logic count;      // coarse counter advances
    logic captEarly;  // latch leader timestamp
    logic captLate;   // latch follower timestamp
    logic earlyRow2;  // leader timestamp taken from row 2 tap
    logic lateRow2;   // follower timestamp taken from row 2 tap
    logic finish;     // conversion resolves at this edge
    logic noEarly;    // no flip seen at all when finishing
    logic noLate;     // follower never flipped when finishing
  } droStrobe_t;

endpackage

// File: rtl/flip_diff_ctrl.sv
module flip_diff_ctrl
  import flip_diff_pkg::*;
#(
  parameter int TAP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             convStart,
  input  logic             rampEnd,
  input  logic             row1Flip,
  input  logic [TAP_W-1:0] row1Tap,
  input  logic             row2Flip,
  input  logic [TAP_W-1:0] row2Tap,
  output droStrobe_t       strb,
  output logic             valid,
  output logic             orderFlag,
  output logic             leadRow1
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} ctrlState_t;

  ctrlState_t state;
  logic haveFirst;
  logic haveLate;
  logic row2Ahead;
  logic followerHit;

  assign row2Ahead   = row2Tap < row1Tap;
  assign followerHit = orderFlag ? row1Flip : row2Flip;

  always_comb begin
    strb       = '0;
    strb.clear = convStart;
    if (!convStart && state == ST_RUN) begin
      strb.count = 1'b1;
      if (!haveFirst) begin
        if (row1Flip && row2Flip) begin
          // same-cycle flips: lower tap leads, ties go to row 1 (R6)
          strb.captEarly = 1'b1;
          strb.captLate  = 1'b1;
          strb.earlyRow2 = row2Ahead;
          strb.lateRow2  = !row2Ahead;
          strb.finish    = 1'b1;
        end else if (row1Flip) begin
          strb.captEarly = 1'b1;
          strb.earlyRow2 = 1'b0;
        end else if (row2Flip) begin
          strb.captEarly = 1'b1;
          strb.earlyRow2 = 1'b1;
        end
      end else if (followerHit) begin
        // follower path stops on its own flip
        strb.captLate = 1'b1;
        strb.lateRow2 = !orderFlag;
        strb.finish   = 1'b1;
      end
      if (rampEnd) strb.finish = 1'b1;
      strb.noEarly = !haveFirst && !strb.captEarly;
      strb.noLate  = !haveLate && !strb.captLate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      haveFirst <= 1'b0;
      haveLate  <= 1'b0;
      orderFlag <= 1'b0;
      leadRow1  <= 1'b1;
    end else if (strb.clear) begin
      state     <= ST_RUN;
      haveFirst <= 1'b0;
      haveLate  <= 1'b0;
      orderFlag <= 1'b0;
      leadRow1  <= 1'b1;
    end else begin
      if (strb.captEarly) begin
        haveFirst <= 1'b1;
        orderFlag <= strb.earlyRow2;
        leadRow1  <= !strb.earlyRow2;
      end
      if (strb.captLate) haveLate <= 1'b1;
      if (strb.finish) state <= ST_DONE;
    end
  end

  assign valid = (state == ST_DONE);

  // R5: leader latch is frozen once the first flip is taken
  assert_order_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && haveFirst && !convStart) |=> ($stable(orderFlag) && $stable(leadRow1)));

  // R1: indicator and order flag are always complementary
  assert_indicator_R1: assert property (@(posedge clk) disable iff (!rst_n)
    leadRow1 != orderFlag);

  // R10: a finished result holds until a new start
  assert_valid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !convStart) |=> valid);

  // R10: results never appear without passing through a run
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !convStart) |=> !valid);

endmodule

// File: rtl/flip_diff_dp.sv
module flip_diff_dp
  import flip_diff_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TAP_W  = 4,
  parameter int DIFF_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  droStrobe_t               strb,
  input  logic                     valid,
  input  logic                     orderFlag,
  input  logic [TAP_W-1:0]         row1Tap,
  input  logic [TAP_W-1:0]         row2Tap,
  output logic [CNT_W+TAP_W-1:0]   earlyCode,
  output logic [DIFF_W-1:0]        diffCode,
  output logic                     diffOvf,
  output logic [CNT_W+TAP_W-1:0]   row1Code,
  output logic [CNT_W+TAP_W-1:0]   row2Code
);

  localparam int TW = CNT_W + TAP_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [TW-1:0]    DIFF_MAX_T = TW'((64'd1 << DIFF_W) - 64'd1);

  logic [CNT_W-1:0] coarse;
  logic [TW-1:0]    earlyT;
  logic [TW-1:0]    lateT;
  logic             noEarlyR;
  logic             noLateR;
  logic [TAP_W-1:0] earlyTap;
  logic [TAP_W-1:0] lateTap;

  assign earlyTap = strb.earlyRow2 ? row2Tap : row1Tap;
  assign lateTap  = strb.lateRow2  ? row2Tap : row1Tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse   <= '0;
      earlyT   <= '0;
      lateT    <= '0;
      noEarlyR <= 1'b0;
      noLateR  <= 1'b0;
    end else if (strb.clear) begin
      coarse   <= '0;
      earlyT   <= '0;
      lateT    <= '0;
      noEarlyR <= 1'b0;
      noLateR  <= 1'b0;
    end else begin
      if (strb.count && coarse != CNT_MAX) coarse <= coarse + 1'b1;
      if (strb.captEarly) earlyT <= {coarse, earlyTap};
      if (strb.captLate)  lateT  <= {coarse, lateTap};
      if (strb.finish) begin
        noEarlyR <= strb.noEarly;
        noLateR  <= strb.noLate;
      end
    end
  end

  logic [TW-1:0]     rawDiff;
  logic [TW-1:0]     leadVal;
  logic [DIFF_W-1:0] diffVal;
  logic              ovfVal;
  logic [TW:0]       sumW;
  logic [TW-1:0]     followVal;

  always_comb begin
    rawDiff = lateT - earlyT;
    if (noEarlyR) begin
      leadVal = '1;
      diffVal = '0;
      ovfVal  = 1'b0;
    end else if (noLateR) begin
      leadVal = earlyT;
      diffVal = '1;
      ovfVal  = 1'b1;
    end else if (rawDiff > DIFF_MAX_T) begin
      leadVal = earlyT;
      diffVal = '1;
      ovfVal  = 1'b1;
    end else begin
      leadVal = earlyT;
      diffVal = rawDiff[DIFF_W-1:0];
      ovfVal  = 1'b0;
    end
    sumW      = {1'b0, leadVal} + {1'b0, TW'(diffVal)};
    followVal = sumW[TW] ? '1 : sumW[TW-1:0];
  end

  always_comb begin
    if (valid) begin
      earlyCode = leadVal;
      diffCode  = diffVal;
      diffOvf   = ovfVal;
      row1Code  = orderFlag ? followVal : leadVal;
      row2Code  = orderFlag ? leadVal : followVal;
    end else begin
      earlyCode = '0;
      diffCode  = '0;
      diffOvf   = 1'b0;
      row1Code  = '0;
      row2Code  = '0;
    end
  end

  // R8: overflow always comes with a saturated code
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    diffOvf |-> (diffCode == {DIFF_W{1'b1}}));

  // R7: a resolved follower stamp never precedes the leader stamp
  assert_late_after_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !noEarlyR && !noLateR) |-> (lateT >= earlyT));

  // R2: coarse time only moves forward within a conversion
  assert_coarse_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clear |=> (coarse >= $past(coarse)));

  // R9: the rebuilt follower is never below the leader
  assert_rebuild_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (orderFlag ? (row1Code >= row2Code) : (row2Code >= row1Code)));

endmodule

// File: rtl/flip_diff_enc.sv
module flip_diff_enc
  import flip_diff_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TAPS   = 16,
  parameter int DIFF_W = 6,
  localparam int TAP_W = $clog2(TAPS),
  localparam int TW    = CNT_W + TAP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             convStart,
  input  logic             rampEnd,
  input  logic             row1Flip,
  input  logic [TAP_W-1:0] row1Tap,
  input  logic             row2Flip,
  input  logic [TAP_W-1:0] row2Tap,
  output logic             valid,
  output logic             orderFlag,
  output logic             leadRow1,
  output logic [TW-1:0]    earlyCode,
  output logic [DIFF_W-1:0] diffCode,
  output logic             diffOvf,
  output logic [TW-1:0]    row1Code,
  output logic [TW-1:0]    row2Code
);

  droStrobe_t strb;

  flip_diff_ctrl #(.TAP_W(TAP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .convStart (convStart),
    .rampEnd   (rampEnd),
    .row1Flip  (row1Flip),
    .row1Tap   (row1Tap),
    .row2Flip  (row2Flip),
    .row2Tap   (row2Tap),
    .strb      (strb),
    .valid     (valid),
    .orderFlag (orderFlag),
    .leadRow1  (leadRow1)
  );

  flip_diff_dp #(.CNT_W(CNT_W), .TAP_W(TAP_W), .DIFF_W(DIFF_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .valid     (valid),
    .orderFlag (orderFlag),
    .row1Tap   (row1Tap),
    .row2Tap   (row2Tap),
    .earlyCode (earlyCode),
    .diffCode  (diffCode),
    .diffOvf   (diffOvf),
    .row1Code  (row1Code),
    .row2Code  (row2Code)
  );

endmodule

// File: tb/flip_diff_enc_bench.sv
module flip_diff_enc_bench;

  localparam int CNT_W  = 5;
  localparam int TAPS   = 8;
  localparam int DIFF_W = 5;
  localparam int TAP_W  = 3;
  localparam int TW     = CNT_W + TAP_W;
  localparam int TMAX   = (1 << TW) - 1;
  localparam int DMAX   = (1 << DIFF_W) - 1;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convStart = 1'b0, rampEnd = 1'b0, row1Flip = 1'b0, row2Flip = 1'b0;
  logic [TAP_W-1:0] row1Tap = '0, row2Tap = '0;
  logic valid, orderFlag, leadRow1, diffOvf;
  logic [TW-1:0] earlyCode, row1Code, row2Code;
  logic [DIFF_W-1:0] diffCode;

  always #4 clk = ~clk;  // 125 MHz

  flip_diff_enc #(.CNT_W(CNT_W), .TAPS(TAPS), .DIFF_W(DIFF_W)) u_flip_diff_enc (
    .clk(clk), .rst_n(rst_n), .convStart(convStart), .rampEnd(rampEnd),
    .row1Flip(row1Flip), .row1Tap(row1Tap), .row2Flip(row2Flip), .row2Tap(row2Tap),
    .valid(valid), .orderFlag(orderFlag), .leadRow1(leadRow1), .earlyCode(earlyCode),
    .diffCode(diffCode), .diffOvf(diffOvf), .row1Code(row1Code), .row2Code(row2Code)
  );

  int nChecks = 0;
  int nFails = 0;
  string reqTag = "R1";

  // behavioural reference state
  int mRun = 0, mDone = 0, mCnt = 0, mHave = 0, mHaveLate = 0, mOrder = 0;
  int mEarly = 0, mLate = 0, mNoE = 0, mNoL = 0;

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelStep(bit st, bit re, bit h1, int t1, bit h2, int t2);
    int fin;
    if (st) begin
      mRun = 1; mDone = 0; mCnt = 0; mHave = 0; mHaveLate = 0; mOrder = 0;
      mEarly = 0; mLate = 0; mNoE = 0; mNoL = 0;
    end else if (mRun != 0) begin
      fin = 0;
      if (mHave == 0) begin
        if (h1 && h2) begin
          mOrder = (t2 < t1) ? 1 : 0;
          mEarly = mCnt * TAPS + (mOrder != 0 ? t2 : t1);
          mLate  = mCnt * TAPS + (mOrder != 0 ? t1 : t2);
          mHave = 1; mHaveLate = 1; fin = 1;
        end else if (h1) begin
          mOrder = 0; mEarly = mCnt * TAPS + t1; mHave = 1;
        end else if (h2) begin
          mOrder = 1; mEarly = mCnt * TAPS + t2; mHave = 1;
        end
      end else if ((mOrder != 0) ? h1 : h2) begin
        mLate = mCnt * TAPS + ((mOrder != 0) ? t1 : t2);
        mHaveLate = 1; fin = 1;
      end
      if (re) fin = 1;
      if (fin != 0) begin
        mRun = 0; mDone = 1; mNoE = (mHave == 0); mNoL = (mHaveLate == 0);
      end
      if (mCnt < CMAX) mCnt++;
    end
  endtask

  task automatic compareAll();
    int eE, eD, eO, eOther, eR1, eR2, d;
    eE = 0; eD = 0; eO = 0; eR1 = 0; eR2 = 0;
    if (mDone != 0) begin
      if (mNoE != 0) begin
        eE = TMAX; eD = 0; eO = 0;
      end else if (mNoL != 0) begin
        eE = mEarly; eD = DMAX; eO = 1;
      end else begin
        eE = mEarly; d = mLate - mEarly;
        if (d > DMAX) begin eD = DMAX; eO = 1; end else begin eD = d; eO = 0; end
      end
      eOther = (eE + eD > TMAX) ? TMAX : eE + eD;
      eR1 = (mOrder != 0) ? eOther : eE;
      eR2 = (mOrder != 0) ? eE : eOther;
    end
    chk(reqTag, "valid", int'(valid), mDone);
    chk(reqTag, "orderFlag", int'(orderFlag), mOrder);
    chk(reqTag, "leadRow1", int'(leadRow1), (mOrder != 0) ? 0 : 1);
    chk(reqTag, "earlyCode", int'(earlyCode), eE);
    chk(reqTag, "diffCode", int'(diffCode), eD);
    chk(reqTag, "diffOvf", int'(diffOvf), eO);
    chk(reqTag, "row1Code", int'(row1Code), eR1);
    chk(reqTag, "row2Code", int'(row2Code), eR2);
  endtask

  task automatic step(bit st, bit re, bit h1, int t1, bit h2, int t2);
    convStart = st; rampEnd = re; row1Flip = h1; row2Flip = h2;
    row1Tap = TAP_W'(t1); row2Tap = TAP_W'(t2);
    @(posedge clk);
    modelStep(st, re, h1, t1, h2, t2);
    #2;
    convStart = 1'b0; rampEnd = 1'b0; row1Flip = 1'b0; row2Flip = 1'b0;
    compareAll();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset state
    reqTag = "R1";
    compareAll();
    idle(2);

    // R3 / R7 / R9: row 1 first at cnt 2 tap 3 (19), row 2 at cnt 4 tap 5 (37)
    reqTag = "R3";
    step(1, 0, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 1, 3, 0, 0);
    idle(1);
    step(0, 0, 0, 0, 1, 5);
    chk("R3", "earlyCode", int'(earlyCode), 19);
    chk("R7", "diffCode", int'(diffCode), 18);
    chk("R9", "row2Code", int'(row2Code), 37);
    idle(1);

    // R4: row 2 first at cnt 1 tap 6 (14), row 1 at cnt 2 tap 1 (17)
    reqTag = "R4";
    step(1, 0, 0, 0, 0, 0);
    idle(1);
    step(0, 0, 0, 0, 1, 6);
    chk("R4", "orderFlag", int'(orderFlag), 1);
    step(0, 0, 1, 1, 0, 0);
    chk("R4", "row1Code", int'(row1Code), 17);
    chk("R4", "diffCode", int'(diffCode), 3);

    // R6: same cycle, row 2 lower tap
    reqTag = "R6";
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 5, 1, 2);
    chk("R6", "earlyCode", int'(earlyCode), 2);
    chk("R6", "orderFlag", int'(orderFlag), 1);
    // R6: equal taps go to row 1 with zero difference
    step(1, 0, 0, 0, 0, 0);
    idle(1);
    step(0, 0, 1, 4, 1, 4);
    chk("R6", "orderFlag", int'(orderFlag), 0);
    chk("R6", "diffCode", int'(diffCode), 0);
    chk("R6", "earlyCode", int'(earlyCode), 12);

    // R8: wide gap saturates (0 vs 81)
    reqTag = "R8";
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    idle(9);
    step(0, 0, 0, 0, 1, 1);
    chk("R8", "diffOvf", int'(diffOvf), 1);
    chk("R8", "diffCode", int'(diffCode), DMAX);

    // R5 / R10: repeat leader flip ignored; post-done events ignored
    reqTag = "R5";
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 2);
    step(0, 0, 0, 0, 1, 7);
    chk("R5", "valid", int'(valid), 0);
    step(0, 0, 1, 0, 0, 0);
    chk("R5", "diffCode", int'(diffCode), 14);
    reqTag = "R10";
    step(0, 0, 1, 7, 1, 7);
    step(0, 1, 0, 0, 1, 3);
    chk("R10", "earlyCode", int'(earlyCode), 2);
    chk("R10", "valid", int'(valid), 1);

    // R11: ramp end with only a leader
    reqTag = "R11";
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 3, 0, 0);
    idle(1);
    step(0, 1, 0, 0, 0, 0);
    chk("R11", "diffOvf", int'(diffOvf), 1);
    chk("R11", "row2Code", int'(row2Code), 34);
    // R11: ramp end with no flip
    step(1, 0, 0, 0, 0, 0);
    idle(3);
    step(0, 1, 0, 0, 0, 0);
    chk("R11", "earlyCode", int'(earlyCode), TMAX);
    chk("R11", "diffCode", int'(diffCode), 0);

    // R2: restart mid-conversion clears leader and count
    reqTag = "R2";
    step(1, 0, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 1, 2, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R2", "valid", int'(valid), 0);
    idle(1);
    step(0, 0, 0, 0, 1, 1);
    step(0, 1, 0, 0, 0, 0);
    chk("R2", "earlyCode", int'(earlyCode), 9);
    chk("R2", "orderFlag", int'(orderFlag), 1);

    // R9: rebuilt follower clamps at full scale (239 + 31)
    reqTag = "R9";
    step(1, 0, 0, 0, 0, 0);
    idle(29);
    step(0, 0, 1, 7, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    chk("R9", "row1Code", int'(row1Code), 239);
    chk("R9", "row2Code", int'(row2Code), TMAX);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule